// File: doc/BRIEF.md
# SMI Event Status and Enable Register

This block is a 32-bit control and status register for the legacy-support function of a USB host controller. It watches three host-side events and turns each into a sticky flag that software clears by writing 1. The events are a write to the controller's base address register, a write to its command register, and any change of the operating-system-owned semaphore. The register also shows live copies of six USB status conditions. These copies are read-only: software clears them only through the USB status register, which lies outside this block.

Each flag and each status copy has its own enable bit. When any enabled source is active, the block raises a registered system-management interrupt request. The request stays high until every enabled source has gone away. Address decoding has already been done by the time a write reaches the block, and every write updates the whole register.

Top module: `smi_evt_ctl`

## Requirements
- R1: After reset, every flag, every enable and `smi_req` are 0. When `usb_sts` is 0, `rd_data` reads 32'h00000000.
- R2: A pulse on `base_wr_evt` sets flag bit 31. A write with bit 31 = 1 clears it. A write with bit 31 = 0 leaves it unchanged.
- R3: A pulse on `cmd_wr_evt` sets flag bit 30. A write with bit 30 = 1 clears it.
- R4: Flag bit 29 sets on a rising edge of `os_own_sem` and also on a falling edge. A write of 1 clears it. Holding the semaphore at the level given by parameter `SEM_RST_LVL` through reset does not set the flag.
- R5: `rd_data[21:16]` always equals `usb_sts[5:0]`. Bit i maps to bit 16+i: 21 async advance, 20 host system error, 19 frame list rollover, 18 port change, 17 USB error, 16 USB interrupt. A write to this register does not change these bits.
- R6: Enable bits 15, 14 and 13 (for flags 31, 30 and 29) and enable bits 5:0 (for `usb_sts[5:0]`) are read/write. Each write loads all of them at once.
- R7: `smi_req` goes high one clock after any enable bit and its matching source are both 1. It goes low one clock after no such pair remains.
- R8: Bits 28:22 and 12:6 read as 0 and ignore writes.
- R9: If an event pulse and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| base_wr_evt | input | 1 | Pulse: base address register was written |
| cmd_wr_evt | input | 1 | Pulse: command register was written |
| os_own_sem | input | 1 | Level of the OS-owned semaphore |
| usb_sts | input | 6 | Live USB status conditions |
| smi_req | output | 1 | Registered SMI request |

## Verification
The bench builds the block with `SEM_RST_LVL` = 1 and holds the semaphore high through reset. This shows that a reset-level mismatch cannot create a false ownership-change flag, and it leaves both transition directions to be driven afterwards. A table of enable and status pairs checks the masking of the six shadow sources and the one-cycle request latency. Directed sequences then cover:
- each event flag, its clear path and its masking;
- writes aimed at the shadow bits and at the reserved bits;
- an event pulse that arrives in the same cycle as a clear.

// File: rtl/smi_evt_pkg.sv
package smi_evt_pkg;

    localparam int REG_W      = 32;
    localparam int EVT_N      = 3;
    localparam int STS_N      = 6;
    localparam int FLAG_LSB   = 29;
    localparam int SHAD_LSB   = 16;
    localparam int EVT_EN_LSB = 13;
    localparam int STS_EN_LSB = 0;

    localparam int EVT_OWN = 0;
    localparam int EVT_CMD = 1;
    localparam int EVT_BAR = 2;

    typedef struct packed {
        logic [EVT_N-1:0] evt_en;
        logic [STS_N-1:0] sts_en;
    } smi_en_t;

    function automatic smi_en_t en_from_word(input logic [REG_W-1:0] w);
        smi_en_t e;
        e.evt_en = w[EVT_EN_LSB +: EVT_N];
        e.sts_en = w[STS_EN_LSB +: STS_N];
        return e;
    endfunction

    function automatic logic [REG_W-1:0] build_read(
        input logic [EVT_N-1:0] flags,
        input logic [STS_N-1:0] shadow,
        input smi_en_t          en
    );
        logic [REG_W-1:0] r;
        r = '0;
        r[FLAG_LSB   +: EVT_N] = flags;
        r[SHAD_LSB   +: STS_N] = shadow;
        r[EVT_EN_LSB +: EVT_N] = en.evt_en;
        r[STS_EN_LSB +: STS_N] = en.sts_en;
        return r;
    endfunction

endpackage

// File: rtl/smi_sticky_flag.sv
module smi_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= set_i | (q_o & ~clr_i);
    end
endmodule

// File: rtl/smi_edge_det.sv
module smi_edge_det #(
    parameter logic RST_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic toggle_o
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= RST_LVL;
        else     level_q <= level_i;
    end

    assign toggle_o = (level_i ^ level_q) & ~rst;
endmodule

// File: rtl/smi_req_gen.sv
module smi_req_gen
    import smi_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_N-1:0] flags_i,
    input  logic [STS_N-1:0] shadow_i,
    input  smi_en_t          en_i,
    output logic             req_o
);
    logic [EVT_N+STS_N-1:0] hit;

    always_comb begin
        hit[EVT_N-1:0]           = flags_i  & en_i.evt_en;
        hit[EVT_N+STS_N-1:EVT_N] = shadow_i & en_i.sts_en;
    end

    always_ff @(posedge clk) begin
        if (rst) req_o <= 1'b0;
        else     req_o <= |hit;
    end
endmodule

// File: rtl/smi_evt_ctl.sv
module smi_evt_ctl
    import smi_evt_pkg::*;
#(
    parameter logic SEM_RST_LVL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             base_wr_evt,
    input  logic             cmd_wr_evt,
    input  logic             os_own_sem,
    input  logic [STS_N-1:0] usb_sts,
    output logic             smi_req
);
    logic [EVT_N-1:0] evt_set;
    logic [EVT_N-1:0] evt_clr;
    logic [EVT_N-1:0] flags;
    logic             own_toggle;
    smi_en_t          en_q;

    smi_edge_det #(.RST_LVL(SEM_RST_LVL)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .level_i  (os_own_sem),
        .toggle_o (own_toggle)
    );

    always_comb begin
        evt_set          = '0;
        evt_set[EVT_BAR] = base_wr_evt;
        evt_set[EVT_CMD] = cmd_wr_evt;
        evt_set[EVT_OWN] = own_toggle;
        evt_clr          = {EVT_N{wr_en}} & wr_data[FLAG_LSB +: EVT_N];
    end

    for (genvar i = 0; i < EVT_N; i++) begin : g_flag
        smi_sticky_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set_i (evt_set[i]),
            .clr_i (evt_clr[i]),
            .q_o   (flags[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (wr_en) en_q <= en_from_word(wr_data);
    end

    smi_req_gen u_req (
        .clk      (clk),
        .rst      (rst),
        .flags_i  (flags),
        .shadow_i (usb_sts),
        .en_i     (en_q),
        .req_o    (smi_req)
    );

    assign rd_data = build_read(flags, usb_sts, en_q);
endmodule

// File: rtl/smi_evt_ctl_chk.sv
module smi_evt_ctl_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        base_wr_evt,
    input logic        cmd_wr_evt,
    input logic        os_own_sem,
    input logic        smi_req
);
    logic src_any;
    assign src_any = (|(rd_data[31:29] & rd_data[15:13])) |
                     (|(rd_data[21:16] & rd_data[5:0]));

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((rd_data & 32'hFFC0FFFF) == 32'h0) && !smi_req); // R1
    AST_BAR_SET: assert property (@(posedge clk) disable iff (rst)
        base_wr_evt |=> rd_data[31]); // R2
    AST_BAR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[31] && !base_wr_evt) |=> !rd_data[31]); // R2
    AST_CMD_SET: assert property (@(posedge clk) disable iff (rst)
        cmd_wr_evt |=> rd_data[30]); // R3
    AST_OWN_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (os_own_sem != $past(os_own_sem))) |=> rd_data[29]); // R4
    AST_SMI_HAS_SRC: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> $past(src_any)); // R7
    AST_SMI_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(src_any)) |-> smi_req); // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[28:22] == 7'h0) && (rd_data[12:6] == 7'h0)); // R8
endmodule

bind smi_evt_ctl smi_evt_ctl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .base_wr_evt (base_wr_evt),
    .cmd_wr_evt  (cmd_wr_evt),
    .os_own_sem  (os_own_sem),
    .smi_req     (smi_req)
);

// File: tb/sim_smi_evt_ctl.sv
`timescale 1ns/1ps
module sim_smi_evt_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        base_wr_evt = 1'b0;
    logic        cmd_wr_evt = 1'b0;
    logic        os_own_sem = 1'b1;
    logic [5:0]  usb_sts = '0;
    logic        smi_req;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    smi_evt_ctl #(.SEM_RST_LVL(1'b1)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .base_wr_evt(base_wr_evt), .cmd_wr_evt(cmd_wr_evt), .os_own_sem(os_own_sem),
        .usb_sts(usb_sts), .smi_req(smi_req)
    );

    // {sts_en[5:0], usb_sts[5:0], expected smi_req}
    localparam logic [12:0] VECS [8] = '{
        {6'b000001, 6'b000001, 1'b1},
        {6'b000001, 6'b000010, 1'b0},
        {6'b100000, 6'b100000, 1'b1},
        {6'b011110, 6'b100001, 1'b0},
        {6'b010100, 6'b000100, 1'b1},
        {6'b000000, 6'b111111, 1'b0},
        {6'b111111, 6'b000000, 1'b0},
        {6'b101010, 6'b001000, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 and R4: semaphore held at reset level, no false change flag
        chk("R1 reset read", rd_data, 32'h0);
        chk("R1 reset smi", {31'h0, smi_req}, 32'h0);

        // R6, R8: enables read back, reserved stay zero
        wr(32'h1FFFFFFF);
        chk("R6 R8 enables and reserved", rd_data, 32'h0000E03F);

        // R5, R7: table of shadow masking
        foreach (VECS[k]) begin
            usb_sts = '0;
            wr({26'h0, VECS[k][12:7]});
            tick();
            usb_sts = VECS[k][6:1];
            #0;
            chk("R5 shadow mirror", {26'h0, rd_data[21:16]}, {26'h0, VECS[k][6:1]});
            tick();
            chk("R7 smi table", {31'h0, smi_req}, {31'h0, VECS[k][0]});
        end

        // R5: write to shadow bits has no effect
        usb_sts = 6'h2A;
        wr(32'h003F0000);
        chk("R5 shadow ignores write", {26'h0, rd_data[21:16]}, 32'h2A);
        usb_sts = '0;
        wr(32'h0);
        tick();
        chk("R7 smi drops", {31'h0, smi_req}, 32'h0);

        // R2: BAR flag set, enable, clear
        wr(32'h00008000);
        base_wr_evt = 1'b1;
        tick();
        base_wr_evt = 1'b0;
        chk("R2 bar set", {31'h0, rd_data[31]}, 32'h1);
        tick();
        chk("R7 smi from bar", {31'h0, smi_req}, 32'h1);
        wr(32'h00008000);
        chk("R2 write zero keeps flag", {31'h0, rd_data[31]}, 32'h1);
        wr(32'h80008000);
        chk("R2 bar clear", {31'h0, rd_data[31]}, 32'h0);
        tick();
        chk("R7 smi released", {31'h0, smi_req}, 32'h0);

        // R3: cmd flag masked by disabled enable
        cmd_wr_evt = 1'b1;
        tick();
        cmd_wr_evt = 1'b0;
        chk("R3 cmd set", {31'h0, rd_data[30]}, 32'h1);
        tick();
        chk("R7 cmd masked", {31'h0, smi_req}, 32'h0);
        wr(32'h40000000);
        chk("R3 cmd clear", {31'h0, rd_data[30]}, 32'h0);

        // R4: both semaphore transitions
        os_own_sem = 1'b0;
        tick();
        chk("R4 falling edge", {31'h0, rd_data[29]}, 32'h1);
        wr(32'h20000000);
        chk("R4 clear", {31'h0, rd_data[29]}, 32'h0);
        tick();
        chk("R4 steady level", {31'h0, rd_data[29]}, 32'h0);
        os_own_sem = 1'b1;
        tick();
        chk("R4 rising edge", {31'h0, rd_data[29]}, 32'h1);
        wr(32'h20000000);

        // R9: event and clear in the same cycle
        base_wr_evt = 1'b1;
        wr(32'h80000000);
        base_wr_evt = 1'b0;
        chk("R9 set wins", {31'h0, rd_data[31]}, 32'h1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule